// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block decides, once per instruction boundary, whether the core takes an interrupt and which source wins. Seven request lines feed it: four general interrupt lines and three I/O lines. It also reads a timer-pending flag that it keeps itself, a 32-bit function control word, and the interrupt-lock flag of the status register. The core pulses `insn_start` at the start of every instruction, before the fetch. The arbiter answers with a one-cycle `take_irq` strobe and a 3-bit trap code, which the core turns into a vector address.

The timer does not have a fixed rank. A 2-bit field in the control word places it in one of four slots that sit between the other sources. A short block counter stops any grant for the first instruction after a call, so the call's entry code runs without interruption. Every control pin is a plain level or strobe. No data moves through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `irq_boundary_arbiter`

## Requirements
- R1: When `lock_flag` is 1 at an instruction boundary, `take_irq` stays 0 for that boundary.
- R2: When the timer is not pending and no request line qualifies, no grant is made.
- R3: Qualified sources are ranked from highest to lowest as follows: IO3, timer slot 3, INT1, timer slot 2, INT2, timer slot 1, INT3, timer slot 0, INT4, IO1, IO2. The highest qualified source wins.
- R4: INT1..INT4 request on `req_lines[0..3]`. Each is masked when `fcr[28..31]` (in the same order) is 1.
- R5: IO1, IO2 and IO3 request on `req_lines[4]`, `[5]` and `[6]`. An IO line qualifies only when its enable bit is 1 and its inhibit bit is 0. The enable bits are `fcr[2]`, `fcr[6]` and `fcr[10]`. The inhibit bits are `fcr[0]`, `fcr[4]` and `fcr[8]`.
- R6: A pending timer takes the slot given by `fcr[21:20]`. `fcr[23]`=1 masks the timer entirely. `fcr[22]` has no effect.
- R7: `timer_fire` sets `timer_pending`. Granting the timer clears it, unless `timer_fire` is high in the same cycle, in which case the fire wins. Granting any other source leaves the flag unchanged.
- R8: A grant is decided at a clock edge where `insn_start` is 1. `take_irq` is high for exactly the following cycle, and `trap_num` carries the code in that cycle. Without `insn_start` there is no grant. Codes: IO3=0, timer=1, INT1..INT4=2..5, IO1=6, IO2=7.
- R9: `call_seen` loads the block counter with 2. Each boundary decrements it, saturating at 0. A boundary may grant only if the counter is 1 or less before the decrement. When `call_seen` and `insn_start` coincide, the boundary uses the old count.
- R10: Synchronous active-high `rst` clears the block counter, `timer_pending` and `take_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | Instruction boundary strobe |
| call_seen | input | 1 | A call instruction executed; loads the block counter |
| lock_flag | input | 1 | Interrupt-lock flag from the status register |
| req_lines | input | 7 | Request lines: INT1..INT4, IO1, IO2, IO3 |
| fcr | input | 32 | Function control word (enables, inhibits, timer slot) |
| timer_fire | input | 1 | Timer compare event; sets the pending flag |
| take_irq | output | 1 | One-cycle grant strobe |
| trap_num | output | 3 | Code of the granted source |
| timer_pending | output | 1 | Timer interrupt pending flag |

## Verification
The bench places the timer in each of its four slots, with a general line just above it and just below it. A design that ranked the timer wrongly would grant the wrong code at those points. It drives IO lines with the enable bit clear or the inhibit bit set, and sets `fcr[22]` and `fcr[23]`. A design that decoded the IO pairs or the timer mask wrongly would grant a masked source. It issues a call and then several boundaries in a row, including a call that lands on a boundary. An off-by-one block counter would grant one instruction too early or too late. It also fires the timer in the same cycle that the timer is granted, and a design that gave the clear priority over the fire would lose that event.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 8;
  localparam int NUM_INT   = 4;
  localparam int NUM_IO    = 3;
  localparam int NUM_REQ   = NUM_INT + NUM_IO;
  localparam int NUM_TSLOT = 4;
  localparam int NUM_SLOTS = NUM_INT + NUM_IO + NUM_TSLOT;
  localparam int CTRL_W    = 32;

  typedef logic [CODE_W-1:0] trap_code_t;

  localparam trap_code_t CODE_IO3  = 3'd0;
  localparam trap_code_t CODE_TMR  = 3'd1;
  localparam trap_code_t CODE_INT1 = 3'd2;

  // control word bit positions
  localparam int POS_INT_INH0 = 28;
  localparam int POS_TSEL_LO  = 20;
  localparam int POS_TMR_INH  = 23;

  // IO index k: 0 = IO1, 1 = IO2, 2 = IO3
  function automatic int io_en_pos(int k);
    return 2 + 4 * k;
  endfunction

  function automatic int io_inh_pos(int k);
    return 4 * k;
  endfunction

  function automatic int io_req_pos(int k);
    return NUM_INT + k;
  endfunction

  function automatic int io_code(int k);
    return (k == 2) ? 0 : 6 + k;
  endfunction

  // ranked slot list, index 0 is the highest
  function automatic bit slot_is_timer(int i);
    return (i <= 7) && ((i % 2) == 1);
  endfunction

  function automatic int slot_tsel(int i);
    return (7 - i) / 2;
  endfunction

  function automatic int slot_code(int i);
    if (slot_is_timer(i)) return 1;
    if (i == 0) return 0;
    if (i <= 8) return i / 2 + 1;
    if (i == 9) return 6;
    return 7;
  endfunction
endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual
  import irq_arb_pkg::*;
(
  input  logic [NUM_REQ-1:0]   req,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic                 tmr_pend,
  output logic [NUM_CODES-1:0] qual,
  output logic [1:0]           tsel
);
  wire unused_ctrl_bits = ^ctrl;

  for (genvar k = 0; k < NUM_INT; k++) begin : g_int
    assign qual[int'(CODE_INT1) + k] = req[k] & ~ctrl[POS_INT_INH0 + k];
  end

  for (genvar k = 0; k < NUM_IO; k++) begin : g_io
    localparam int EN  = io_en_pos(k);
    localparam int INH = io_inh_pos(k);
    localparam int RQ  = io_req_pos(k);
    localparam int CD  = io_code(k);
    assign qual[CD] = req[RQ] & ctrl[EN] & ~ctrl[INH];
  end

  assign qual[CODE_TMR] = tmr_pend & ~ctrl[POS_TMR_INH];
  assign tsel           = ctrl[POS_TSEL_LO +: 2];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
(
  input  logic [NUM_CODES-1:0] qual,
  input  logic [1:0]           tsel,
  output logic                 any,
  output trap_code_t           code
);
  logic [NUM_SLOTS-1:0] hit;
  trap_code_t           slot_cd [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int SC = slot_code(i);
    assign slot_cd[i] = trap_code_t'(SC);
    if (slot_is_timer(i)) begin : g_t
      localparam int TS = slot_tsel(i);
      assign hit[i] = qual[CODE_TMR] & (tsel == 2'(TS));
    end else begin : g_s
      assign hit[i] = qual[SC];
    end
  end

  always_comb begin
    any  = 1'b0;
    code = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any  = 1'b1;
        code = slot_cd[i];
      end
    end
  end
endmodule

// File: rtl/irq_block_ctr.sv
module irq_block_ctr #(
  parameter int LOAD_VAL = 2,
  localparam int CNT_W   = $clog2(LOAD_VAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_start,
  input  logic             call_seen,
  output logic             check_en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  assign check_en = (cnt_q <= CNT_W'(1));
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (call_seen)
      cnt_q <= CNT_W'(LOAD_VAL);
    else if (insn_start && cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/irq_boundary_arbiter.sv
module irq_boundary_arbiter
  import irq_arb_pkg::*;
#(
  parameter int BLOCK_LOAD = 2,
  localparam int CNT_W     = $clog2(BLOCK_LOAD + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_start,
  input  logic               call_seen,
  input  logic               lock_flag,
  input  logic [NUM_REQ-1:0] req_lines,
  input  logic [CTRL_W-1:0]  fcr,
  input  logic               timer_fire,
  output logic               take_irq,
  output logic [CODE_W-1:0]  trap_num,
  output logic               timer_pending
);
  logic [NUM_CODES-1:0] qual;
  logic [1:0]           tsel;
  logic                 any;
  trap_code_t           code;
  logic                 check_en;
  logic [CNT_W-1:0]     blk_cnt;
  logic                 grant_d;

  irq_src_qual u_qual (
    .req      (req_lines),
    .ctrl     (fcr),
    .tmr_pend (timer_pending),
    .qual     (qual),
    .tsel     (tsel)
  );

  irq_prio_pick u_pick (
    .qual (qual),
    .tsel (tsel),
    .any  (any),
    .code (code)
  );

  irq_block_ctr #(.LOAD_VAL(BLOCK_LOAD)) u_blk (
    .clk        (clk),
    .rst        (rst),
    .insn_start (insn_start),
    .call_seen  (call_seen),
    .check_en   (check_en),
    .cnt        (blk_cnt)
  );

  assign grant_d = insn_start & check_en & ~lock_flag & any;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq      <= 1'b0;
      trap_num      <= '0;
      timer_pending <= 1'b0;
    end else begin
      take_irq <= grant_d;
      if (grant_d)
        trap_num <= code;
      if (timer_fire)
        timer_pending <= 1'b1;
      else if (grant_d && code == CODE_TMR)
        timer_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int BLOCK_LOAD = 2,
  localparam int CNT_W     = $clog2(BLOCK_LOAD + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_start,
  input logic             call_seen,
  input logic             lock_flag,
  input logic [31:0]      fcr,
  input logic             timer_fire,
  input logic             take_irq,
  input logic [2:0]       trap_num,
  input logic             timer_pending,
  input logic [CNT_W-1:0] blk_cnt
);
  p_lock_r1: assert property (@(posedge clk) disable iff (rst)
    insn_start && lock_flag |=> !take_irq);

  p_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(insn_start));

  p_io3_inh_r5: assert property (@(posedge clk) disable iff (rst)
    insn_start && fcr[8] |=> !(take_irq && trap_num == 3'd0));

  p_tmr_inh_r6: assert property (@(posedge clk) disable iff (rst)
    insn_start && fcr[23] |=> !(take_irq && trap_num == 3'd1));

  p_tmr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    take_irq && trap_num == 3'd1 && !$past(timer_fire) |-> !timer_pending);

  p_tmr_keep_r7: assert property (@(posedge clk) disable iff (rst)
    take_irq && trap_num != 3'd1 && !$past(timer_fire)
      |-> timer_pending == $past(timer_pending));

  p_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    insn_start && blk_cnt > CNT_W'(1) |=> !take_irq);

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    call_seen |=> blk_cnt == CNT_W'(BLOCK_LOAD));

  p_cnt_max_r9: assert property (@(posedge clk) disable iff (rst)
    blk_cnt <= CNT_W'(BLOCK_LOAD));
endmodule

bind irq_boundary_arbiter irq_arb_chk #(.BLOCK_LOAD(BLOCK_LOAD)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .insn_start    (insn_start),
  .call_seen     (call_seen),
  .lock_flag     (lock_flag),
  .fcr           (fcr),
  .timer_fire    (timer_fire),
  .take_irq      (take_irq),
  .trap_num      (trap_num),
  .timer_pending (timer_pending),
  .blk_cnt       (blk_cnt)
);

// File: tb/test_irq_boundary_arbiter.sv
module test_irq_boundary_arbiter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_start = 1'b0;
  logic        call_seen = 1'b0;
  logic        lock_flag = 1'b0;
  logic [6:0]  req_lines = '0;
  logic [31:0] fcr = '0;
  logic        timer_fire = 1'b0;
  logic        take_irq;
  logic [2:0]  trap_num;
  logic        timer_pending;

  int total = 0;
  int bad   = 0;
  int m_cnt = 0;
  bit m_pend = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  irq_boundary_arbiter i_irq_boundary_arbiter (
    .clk (clk), .rst (rst), .insn_start (insn_start), .call_seen (call_seen),
    .lock_flag (lock_flag), .req_lines (req_lines), .fcr (fcr),
    .timer_fire (timer_fire), .take_irq (take_irq), .trap_num (trap_num),
    .timer_pending (timer_pending)
  );

  // returns {any, code} per R3..R6
  function automatic logic [3:0] ref_pick(logic [6:0] rq, logic [31:0] f, bit pend);
    bit tq = pend && !f[23];
    int ts = int'(f[21:20]);
    if (rq[6] && f[10] && !f[8])  return 4'b1_000;
    if (tq && ts == 3)            return 4'b1_001;
    if (rq[0] && !f[28])          return 4'b1_010;
    if (tq && ts == 2)            return 4'b1_001;
    if (rq[1] && !f[29])          return 4'b1_011;
    if (tq && ts == 1)            return 4'b1_001;
    if (rq[2] && !f[30])          return 4'b1_100;
    if (tq && ts == 0)            return 4'b1_001;
    if (rq[3] && !f[31])          return 4'b1_101;
    if (rq[4] && f[2] && !f[0])   return 4'b1_110;
    if (rq[5] && f[6] && !f[4])   return 4'b1_111;
    return 4'b0_000;
  endfunction

  task automatic step(bit ins, bit call, bit lock, logic [6:0] rq,
                      logic [31:0] f, bit fire, string tag);
    logic [3:0] pk;
    bit g;
    insn_start = ins; call_seen = call; lock_flag = lock;
    req_lines = rq; fcr = f; timer_fire = fire;
    pk = ref_pick(rq, f, m_pend);
    g  = ins && (m_cnt <= 1) && !lock && pk[3];
    if (fire) m_pend = 1'b1;
    else if (g && pk[2:0] == 3'd1) m_pend = 1'b0;
    if (call) m_cnt = 2;
    else if (ins && m_cnt > 0) m_cnt = m_cnt - 1;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (take_irq !== g || (g && trap_num !== pk[2:0]) || timer_pending !== m_pend) begin
      bad++;
      $display("FAIL %s: take=%0b code=%0d pend=%0b expected take=%0b code=%0d pend=%0b",
               tag, take_irq, trap_num, timer_pending, g, pk[2:0], m_pend);
    end
  endtask

  localparam logic [31:0] IO_ON = 32'h0000_0444;

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (take_irq !== 1'b0 || timer_pending !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: take=%0b pend=%0b expected 0 0", take_irq, timer_pending);
    end
    // R2: nothing pending, nothing requested
    step(1, 0, 0, 7'h00, IO_ON, 0, "R2 idle");
    // R8: requests without boundary strobe
    step(0, 0, 0, 7'h7f, IO_ON, 0, "R8 no strobe");
    // R1: lock blocks everything
    step(1, 0, 1, 7'h7f, IO_ON, 0, "R1 locked");
    // R3/R5: IO3 beats all
    step(1, 0, 0, 7'h7f, IO_ON, 0, "R3 io3 top");
    // R5: IO3 disabled / inhibited, IO pairs
    step(1, 0, 0, 7'h40, 32'h0000_0000, 0, "R5 io3 not enabled");
    step(1, 0, 0, 7'h40, 32'h0000_0500, 0, "R5 io3 inhibited");
    step(1, 0, 0, 7'h70, 32'h0000_0045, 0, "R5 io1 inhibited io2 wins");
    step(1, 0, 0, 7'h30, 32'h0000_0044, 0, "R3 io1 over io2");
    // R4: INT inhibits
    step(1, 0, 0, 7'h0f, 32'h1000_0000, 0, "R4 int1 masked");
    step(1, 0, 0, 7'h0f, 32'hF000_0000, 0, "R4 all int masked");
    step(1, 0, 0, 7'h08, 32'h7000_0000, 0, "R4 int4 alone");
    // R6/R7: timer in each slot
    for (int s = 0; s < 4; s++) begin
      logic [31:0] fs = 32'(s) << 20;
      step(0, 0, 0, 7'h00, fs, 1, "R7 fire");
      // general line just above the slot wins first
      if (s < 3) step(1, 0, 0, 7'(1 << (3 - s - 1)), fs, 0, "R6 slot above");
      if (s > 0) step(1, 0, 0, 7'(1 << (3 - s)), fs, 0, "R6 slot below loses");
      else step(1, 0, 0, 7'h08, fs, 0, "R6 slot0 over int4");
    end
    // R6: bit 23 masks, bit 22 ignored
    step(0, 0, 0, 7'h00, 32'h0080_0000, 1, "R7 fire");
    step(1, 0, 0, 7'h00, 32'h00B0_0000, 0, "R6 timer masked");
    step(1, 0, 0, 7'h01, 32'h0070_0000, 0, "R6 bit22 ignored");
    // R7: fire coinciding with timer grant
    step(0, 0, 0, 7'h00, 32'h0030_0000, 1, "R7 fire");
    step(1, 0, 0, 7'h00, 32'h0030_0000, 1, "R7 fire wins over clear");
    step(1, 0, 0, 7'h01, 32'h0080_0000, 0, "R7 other grant keeps pend");
    step(1, 0, 0, 7'h00, 32'h0000_0000, 0, "R7 timer taken");
    // R9: block after call
    step(0, 1, 0, 7'h01, 32'h0, 0, "R9 call");
    step(1, 0, 0, 7'h01, 32'h0, 0, "R9 blocked");
    step(1, 0, 0, 7'h01, 32'h0, 0, "R9 released");
    step(1, 1, 0, 7'h01, 32'h0, 0, "R9 call on boundary");
    step(1, 0, 0, 7'h01, 32'h0, 0, "R9 blocked again");
    step(0, 0, 0, 7'h01, 32'h0, 0, "R9 no boundary");
    step(1, 0, 0, 7'h01, 32'h0, 0, "R9 released again");
    // random mix, R3 main
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] f = $urandom;
      if ($urandom % 2) f = (f & ~32'hF080_0111) | IO_ON;
      step(($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
           7'($urandom), f, ($urandom % 4) == 0, "R3 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule